// File: doc/BRIEF.md
# Dual-Role SPI Byte Transceiver

This block moves one data word at a time over a four-wire serial link and can take either end of that link. A configuration write picks the role, the bit order, the resting level of the serial clock, which clock edge captures data, and, in the driving role, the serial clock speed. As the driving end, it makes the serial clock from the system clock. A write of a data word starts the exchange. The word received in return is kept in a read buffer.

As the driven end, it follows an external serial clock that is qualified by an active-low select input. It returns the word that was loaded in advance. A completion flag reports every finished exchange. While the block is in the driving role, the select input is also watched. If another device pulls it low, the block drops to the driven role by itself and raises the completion flag, so that software can see the conflict.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the block is in the driven role, the completion flag and busy are 0, the serial clock rests at 0, and neither data output nor the clock output is enabled.
- R2: In the driving role, one serial clock half period lasts 2, 8, 32 or 64 system cycles for rate code 0, 1, 2, 3 with the speed-doubling bit at 0, and 1, 4, 16, 32 cycles with it at 1. One exchange has exactly 16 clock edges.
- R3: The serial clock rests high between exchanges when the polarity bit is 1 and low when it is 0.
- R4: With the phase bit at 0, data is captured on the leading edge (the first edge away from the resting level) and changed on the trailing edge. With the phase bit at 1, data is changed on the leading edge and captured on the trailing edge.
- R5: With the order bit at 1 the word is sent and received least significant bit first. With the order bit at 0 it is sent and received most significant bit first.
- R6: In the driving role, a data write starts an exchange only when the block is not busy. A data write during an exchange changes neither the bits sent nor the word received.
- R7: When an exchange completes, the completion flag becomes 1 and the received word appears on rx_data.
- R8: The completion flag is cleared by a data write or by a pulse on done_clr. A completion in the same cycle wins.
- R9: When the block is in the driving role and the select input is seen low, the role bit clears, any exchange stops, the clock returns to its resting level and the completion flag is set. The driving role returns only when it is written again.
- R10: In the driven role the block shifts on the external clock whatever the rate setting is. It drives the returned data output only while select is low, and it does not enable its clock output.
- R11: In the driven role, while select is high, clock edges are ignored and the bit count returns to zero, so that an exchange cut short does not shift the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load all configuration fields |
| cfg_master | input | 1 | 1 selects the driving role |
| cfg_lsb_first | input | 1 | Bit order, 1 sends LSB first |
| cfg_cpol | input | 1 | Serial clock resting level |
| cfg_cpha | input | 1 | 1 captures on the trailing edge |
| cfg_rate | input | 2 | Clock rate code |
| cfg_dbl | input | 1 | Halves the selected divisor |
| tx_wr | input | 1 | Data write strobe |
| tx_data | input | DATA_W | Word to send |
| done_clr | input | 1 | Clears the completion flag |
| rx_data | output | DATA_W | Last received word |
| done_o | output | 1 | Completion flag |
| is_master | output | 1 | Current role bit |
| busy_o | output | 1 | Driving-role exchange in progress |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Enable for sck_o |
| mosi_o | output | 1 | Data out in the driving role |
| mosi_oe | output | 1 | Enable for mosi_o |
| miso_i | input | 1 | Data in for the driving role |
| miso_o | output | 1 | Data out in the driven role |
| miso_oe | output | 1 | Enable for miso_o |
| sck_i | input | 1 | External serial clock |
| mosi_i | input | 1 | Data in for the driven role |
| ss_n_i | input | 1 | Active-low select |

## Verification
The properties assume that configuration is written only while no exchange is running and that the external clock, data and select inputs change slowly compared with the system clock, with each level held for several cycles. They also assume that the response on miso_i to the generated clock settles within one half period. The stimulus follows these assumptions. The bench writes configuration only between exchanges. In the driven role it holds every external clock level for eight cycles. In the driving role it returns the inverted data output on miso_i through a combinational path.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  localparam int RATE_W = 2;

  // half period of the generated serial clock, in system cycles
  function automatic int half_cycles(input logic [RATE_W-1:0] rate, input logic dbl);
    int e;
    case (rate)
      2'd0:    e = 1;
      2'd1:    e = 3;
      2'd2:    e = 5;
      default: e = 6;
    endcase
    return 1 << (e - int'(dbl));
  endfunction

endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[g] <= RST_VAL;
      end else begin
        if (g == 0) stg[g] <= d;
        else        stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_xcvr_clkgen.sv
module spi_xcvr_clkgen
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [RATE_W-1:0] rate,
  input  logic              dbl,
  output logic              busy,
  output logic              phase,
  output logic              lead,
  output logic              trail,
  output logic              last
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [HALF_W-1:0] cnt_q;
  logic [EW-1:0]     edge_q;
  logic              busy_q, phase_q;
  logic [HALF_W-1:0] reload;
  logic              tick;

  assign reload = HALF_W'(half_cycles(rate, dbl) - 1);
  assign tick   = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      edge_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      cnt_q   <= reload;
      edge_q  <= '0;
    end else if (tick) begin
      phase_q <= ~phase_q;
      cnt_q   <= reload;
      edge_q  <= edge_q + 1'b1;
      if (edge_q == EW'(EDGES - 1)) busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy  = busy_q;
  assign phase = phase_q;
  assign lead  = tick && !phase_q;
  assign trail = tick && phase_q;
  assign last  = tick && (edge_q == EW'(EDGES - 1));

endmodule

// File: rtl/spi_xcvr_shifter.sv
module spi_xcvr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_present,
  input  logic              present,
  input  logic              sample,
  input  logic              din,
  input  logic              lsb_first,
  input  logic              clr,
  output logic              dout,
  output logic [DATA_W-1:0] rx_now,
  output logic              last_sample
);

  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] tsr_q, rsr_q, rsr_next;
  logic [CW-1:0]     cnt_q;
  logic              dout_q;

  function automatic logic head(input logic [DATA_W-1:0] x, input logic lsb);
    return lsb ? x[0] : x[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] adv(input logic [DATA_W-1:0] x, input logic lsb);
    return lsb ? {1'b0, x[DATA_W-1:1]} : {x[DATA_W-2:0], 1'b0};
  endfunction

  assign rsr_next = lsb_first ? {din, rsr_q[DATA_W-1:1]} : {rsr_q[DATA_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      tsr_q  <= '0;
      dout_q <= 1'b0;
    end else if (load) begin
      if (load_present) begin
        dout_q <= head(load_data, lsb_first);
        tsr_q  <= adv(load_data, lsb_first);
      end else begin
        tsr_q  <= load_data;
      end
    end else if (present) begin
      dout_q <= head(tsr_q, lsb_first);
      tsr_q  <= adv(tsr_q, lsb_first);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sample) rsr_q <= rsr_next;
      if (load || clr)    cnt_q <= '0;
      else if (sample)    cnt_q <= (cnt_q == CW'(DATA_W - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign dout        = dout_q;
  assign rx_now      = sample ? rsr_next : rsr_q;
  assign last_sample = sample && (cnt_q == CW'(DATA_W - 1));

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_master,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_dbl,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              done_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_o,
  output logic              is_master,
  output logic              busy_o,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_n_i
);

  // configuration
  logic              master_q, lsb_q, cpol_q, cpha_q, dbl_q;
  logic [RATE_W-1:0] rate_q;

  // synchronised external inputs: {ss, mosi, sck}
  logic [2:0] pins_s;
  logic       sck_s, mosi_s, ss_s;
  logic       sck_prev_q, ss_prev_q;

  // edge generator and shifter interface
  logic m_busy, m_phase, m_lead, m_trail, m_last;
  logic s_act, s_lead, s_trail, ss_fall;
  logic fault, m_start, sh_load, sh_load_pres, sh_present, sh_sample, sh_din;
  logic sh_dout, sh_last;
  logic [DATA_W-1:0] sh_rx;
  logic fin, done_set;
  logic done_q;
  logic [DATA_W-1:0] rx_q;

  spi_xcvr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n_i, mosi_i, sck_i}),
    .q   (pins_s)
  );
  assign sck_s  = pins_s[0];
  assign mosi_s = pins_s[1];
  assign ss_s   = pins_s[2];

  assign fault = master_q && !ss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      lsb_q    <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      rate_q   <= '0;
      dbl_q    <= 1'b0;
    end else begin
      if (cfg_wr) begin
        lsb_q    <= cfg_lsb_first;
        cpol_q   <= cfg_cpol;
        cpha_q   <= cfg_cpha;
        rate_q   <= cfg_rate;
        dbl_q    <= cfg_dbl;
      end
      if (fault)       master_q <= 1'b0;
      else if (cfg_wr) master_q <= cfg_master;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev_q <= 1'b0;
      ss_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      ss_prev_q  <= ss_s;
    end
  end

  // driven-role edge detection relative to the resting level
  assign s_act   = !master_q && !ss_s;
  assign s_lead  = s_act && (sck_s ^ cpol_q) && !(sck_prev_q ^ cpol_q);
  assign s_trail = s_act && !(sck_s ^ cpol_q) && (sck_prev_q ^ cpol_q);
  assign ss_fall = !master_q && ss_prev_q && !ss_s;

  assign m_start = master_q && tx_wr && !m_busy && !fault;

  spi_xcvr_clkgen #(.DATA_W(DATA_W), .HALF_W(HALF_W)) clkgen_i (
    .clk   (clk),
    .rst   (rst),
    .start (m_start),
    .abort (fault || !master_q),
    .rate  (rate_q),
    .dbl   (dbl_q),
    .busy  (m_busy),
    .phase (m_phase),
    .lead  (m_lead),
    .trail (m_trail),
    .last  (m_last)
  );

  assign sh_load      = m_start || (!master_q && tx_wr && ss_s);
  assign sh_load_pres = m_start && !cpha_q;
  assign sh_present   = master_q ? (cpha_q ? m_lead : m_trail)
                                 : ((cpha_q ? s_lead : s_trail) || (ss_fall && !cpha_q));
  assign sh_sample    = master_q ? (cpha_q ? m_trail : m_lead)
                                 : (cpha_q ? s_trail : s_lead);
  assign sh_din       = master_q ? miso_i : mosi_s;

  spi_xcvr_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk          (clk),
    .rst          (rst),
    .load         (sh_load),
    .load_data    (tx_data),
    .load_present (sh_load_pres),
    .present      (sh_present),
    .sample       (sh_sample),
    .din          (sh_din),
    .lsb_first    (lsb_q),
    .clr          (!master_q && ss_s),
    .dout         (sh_dout),
    .rx_now       (sh_rx),
    .last_sample  (sh_last)
  );

  assign fin      = (master_q && m_last) || (!master_q && sh_last);
  assign done_set = fin || fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      if (fin) rx_q <= sh_rx;
      if (done_set)                done_q <= 1'b1;
      else if (tx_wr || done_clr)  done_q <= 1'b0;
    end
  end

  assign rx_data   = rx_q;
  assign done_o    = done_q;
  assign is_master = master_q;
  assign busy_o    = m_busy;
  assign sck_o     = cpol_q ^ m_phase;
  assign sck_oe    = master_q;
  assign mosi_o    = sh_dout;
  assign mosi_oe   = master_q;
  assign miso_o    = sh_dout;
  assign miso_oe   = s_act;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic master_q,
  input logic ss_s,
  input logic cpol_q,
  input logic done_clr,
  input logic done_set,
  input logic done_o,
  input logic is_master,
  input logic busy_o,
  input logic sck_o,
  input logic sck_oe,
  input logic miso_oe
);

  // R9: a low select while driving demotes and flags
  a_r9_fault_demotes: assert property (@(posedge clk) disable iff (rst)
    (master_q && !ss_s) |=> (!is_master && done_o));

  // R8: an explicit clear without a completing event drops the flag
  a_r8_clear_flag: assert property (@(posedge clk) disable iff (rst)
    (done_clr && !done_set) |=> !done_o);

  // R6: an exchange only runs in the driving role
  a_r6_busy_needs_master: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> is_master);

  // R3: idle clock sits at the polarity level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (sck_o == cpol_q));

  // R10: never drive both role outputs at once
  a_r10_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sck_oe && miso_oe));

  // R11: deselected driven role keeps its output off
  a_r11_ss_high_quiet: assert property (@(posedge clk) disable iff (rst)
    (!is_master && ss_s) |-> !miso_oe);

endmodule

bind spi_xcvr spi_xcvr_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .master_q  (master_q),
  .ss_s      (ss_s),
  .cpol_q    (cpol_q),
  .done_clr  (done_clr),
  .done_set  (done_set),
  .done_o    (done_o),
  .is_master (is_master),
  .busy_o    (busy_o),
  .sck_o     (sck_o),
  .sck_oe    (sck_oe),
  .miso_oe   (miso_oe)
);

// File: tb/spi_xcvr_tb_top.sv
`timescale 1ns/1ps
module spi_xcvr_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       cfg_wr = 0, cfg_master = 0, cfg_lsb_first = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_dbl = 0;
  logic [1:0] cfg_rate = 0;
  logic       tx_wr = 0, done_clr = 0;
  logic [7:0] tx_data = 0;
  logic [7:0] rx_data;
  logic done_o, is_master, busy_o, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic miso_i;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;

  assign miso_i = ~mosi_o;

  spi_xcvr dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_master(cfg_master),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_rate(cfg_rate), .cfg_dbl(cfg_dbl), .tx_wr(tx_wr), .tx_data(tx_data),
    .done_clr(done_clr), .rx_data(rx_data), .done_o(done_o), .is_master(is_master),
    .busy_o(busy_o), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .sck_i(sck_i),
    .mosi_i(mosi_i), .ss_n_i(ss_n_i)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  logic cpol_tb = 0, cpha_tb = 0;
  logic [7:0] exp_q [$];

  // bench-side observation of the generated clock
  logic       prev_sck = 0, prev_done = 0;
  int         ecount = 0, t_first = 0, t_last = 0, ncap = 0;
  logic [7:0] cap = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  // monitor: edge capture and scoreboard on completion
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (sck_oe && sck_o != prev_sck) begin
        ecount = ecount + 1;
        if (ecount == 1) t_first = cyc;
        t_last = cyc;
        if ((cpha_tb == 0) == (sck_o != cpol_tb)) begin
          cap  = {cap[6:0], mosi_o};
          ncap = ncap + 1;
        end
      end
      if (done_o && !prev_done && exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R7 scoreboard rx_data", rx_data, e);
      end
    end
    prev_sck  = sck_o;
    prev_done = done_o;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic do_cfg(input logic m, input logic lsb, input logic cp, input logic ch,
                        input logic [1:0] rate, input logic dbl);
    @(negedge clk);
    cfg_wr = 1; cfg_master = m; cfg_lsb_first = lsb; cfg_cpol = cp; cfg_cpha = ch;
    cfg_rate = rate; cfg_dbl = dbl;
    cpol_tb = cp; cpha_tb = ch;
    @(negedge clk);
    cfg_wr = 0;
    @(negedge clk);
  endtask

  task automatic pulse_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic master_xfer(input logic [7:0] d, input logic lsb, input int half, input bit intrude);
    ecount = 0; ncap = 0; cap = 0;
    exp_q.push_back(~d);
    pulse_tx(d);
    chk(done_o == 0, "R8 data write clears flag", done_o, 0);
    chk(busy_o == 1, "R6 exchange starts when idle", busy_o, 1);
    if (intrude) begin
      repeat (5) @(negedge clk);
      pulse_tx(~d ^ 8'h5A);
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(ecount == 16, "R2 edge count", ecount, 16);
    chk(t_last - t_first == 15 * half, "R2 half period", t_last - t_first, 15 * half);
    chk(cap == (lsb ? rev8(d) : d), "R4/R5 bits at capture edges", cap, lsb ? rev8(d) : d);
    chk(sck_o == cpol_tb, "R3 idle level", sck_o, cpol_tb);
    chk(done_o == 1, "R7 completion flag", done_o, 1);
  endtask

  task automatic slave_xfer(input logic [7:0] din, input logic [7:0] dtx, input logic lsb);
    logic [7:0] got;
    got = 0;
    exp_q.push_back(din);
    pulse_tx(dtx);
    sck_i = cpol_tb;
    repeat (8) @(negedge clk);
    ss_n_i = 0;
    repeat (8) @(negedge clk);
    chk(miso_oe == 1, "R10 output on while selected", miso_oe, 1);
    chk(sck_oe == 0, "R10 no clock drive in driven role", sck_oe, 0);
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      if (cpha_tb == 0) begin
        mosi_i = din[idx];
        repeat (8) @(negedge clk);
        got[idx] = miso_o;
        sck_i = ~cpol_tb;
        repeat (8) @(negedge clk);
        sck_i = cpol_tb;
      end else begin
        sck_i = ~cpol_tb;
        mosi_i = din[idx];
        repeat (8) @(negedge clk);
        got[idx] = miso_o;
        sck_i = cpol_tb;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(done_o == 1, "R10 driven role completes", done_o, 1);
    chk(got == dtx, "R10/R5 returned bits", got, dtx);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    chk(miso_oe == 0, "R10 output off when deselected", miso_oe, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(done_o == 0 && busy_o == 0, "R1 flag and busy", {done_o, busy_o}, 0);
    chk(is_master == 0 && sck_o == 0, "R1 role and clock", {is_master, sck_o}, 0);
    chk(miso_oe == 0 && sck_oe == 0 && mosi_oe == 0, "R1 enables", {miso_oe, sck_oe, mosi_oe}, 0);

    // driving role, several settings (R2 R3 R4 R5)
    do_cfg(1, 0, 0, 0, 2'd0, 0);
    master_xfer(8'hA5, 0, 2, 0);
    do_cfg(1, 1, 1, 1, 2'd1, 1);
    master_xfer(8'h3C, 1, 4, 0);
    do_cfg(1, 0, 0, 1, 2'd3, 0);
    master_xfer(8'hC1, 0, 64, 0);
    do_cfg(1, 1, 1, 0, 2'd2, 1);
    master_xfer(8'h96, 1, 16, 0);
    do_cfg(1, 0, 0, 0, 2'd0, 1);
    master_xfer(8'h4E, 0, 1, 0);
    // R6 write during exchange ignored
    do_cfg(1, 0, 1, 0, 2'd1, 0);
    master_xfer(8'h71, 0, 8, 1);
    // R8 explicit clear
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    chk(done_o == 0, "R8 explicit clear", done_o, 1'b0);

    // R9 mode fault mid-exchange
    do_cfg(1, 0, 1, 0, 2'd1, 0);
    pulse_tx(8'h0F);
    repeat (20) @(negedge clk);
    ss_n_i = 0;
    repeat (4) @(negedge clk);
    chk(is_master == 0, "R9 role cleared", is_master, 0);
    chk(done_o == 1, "R9 flag set", done_o, 1);
    chk(busy_o == 0 && sck_o == 1, "R9 stopped at rest", {busy_o, sck_o}, 2'b01);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
    chk(is_master == 0, "R9 stays demoted", is_master, 0);
    do_cfg(1, 0, 1, 0, 2'd1, 0);
    chk(is_master == 1, "R9 rewrite restores role", is_master, 1);

    // driven role (R10), rate bits set to varied values
    do_cfg(0, 0, 0, 0, 2'd3, 1);
    slave_xfer(8'h5C, 8'hB2, 0);
    do_cfg(0, 1, 1, 1, 2'd0, 0);
    slave_xfer(8'hE4, 8'h19, 1);

    // R11 edges ignored while deselected, and partial exchange discarded
    do_cfg(0, 0, 0, 1, 2'd2, 0);
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    for (int k = 0; k < 20; k++) begin
      sck_i = ~sck_i;
      repeat (8) @(negedge clk);
    end
    sck_i = 0;
    repeat (8) @(negedge clk);
    chk(done_o == 0, "R11 edges ignored when deselected", done_o, 0);
    ss_n_i = 0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      sck_i = ~sck_i;
      repeat (8) @(negedge clk);
    end
    ss_n_i = 1;
    repeat (8) @(negedge clk);
    slave_xfer(8'h2D, 8'hD3, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all completions seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule